// File: doc/BRIEF.md
# Layered Min-Sum Variable Node Unit

This block holds the bit-side state of a layered scaled min-sum decoder for a code whose every variable sits in three check layers. A decode starts with a `start` pulse, after which the unit takes one channel LLR per variable over a valid/ready load stream. Positions flagged as shortened are pinned to the largest positive LLR, which is how a shorter, lower-rate code is carved out of the mother code. Loading also clears the stored check messages and sets the hard decisions.

During decoding the external check-node side asks for a variable in a given layer over the request stream. The unit subtracts that layer's stored check message from the posterior and sends the result out on a registered valid/ready message stream. When the check side hands back the new check message on the return stream, the unit adds it to the outgoing message it kept, saturates the sum and writes it as the new posterior. It also stores the new message for that layer and refreshes the decoded bit.

The check side pulses `iter_end` at the end of each iteration, with `checks_ok` high if every parity check holds on the current hard decisions. The unit then stops early, or stops when the iteration cap is reached. Back-pressure: a request is taken only when `vn_valid` and `vn_ready` are both high. `vn_ready` is low while a held output message is not accepted. An output message stays fixed from the cycle it appears until `vtc_ready` is seen high. Returns and loads are taken whenever the unit is in the matching phase.

Top module: `ldpc_vnu`

## Requirements
- R1: After `start`, `ld_ready` is high until exactly N_VAR LLRs have been accepted, and then it goes low. Request and return readies are low while loading.
- R2: Every stored LLR lies in [-127, +127]. A loaded value of -128 is stored as -127. A position loaded with `ld_short` high is stored as +127, whatever its LLR.
- R3: Loading clears all three stored check messages of a variable, so the first request for any layer yields the loaded posterior unchanged.
- R4: The outgoing message for (variable, layer) equals the saturated difference of the current posterior minus that layer's stored check message.
- R5: A return sets the posterior to the saturated sum of the variable's last outgoing message and the returned message, clamped to [-127, +127]. It also replaces that layer's stored check message with the clamped returned message.
- R6: `hd_bit` at `hd_addr` is 1 when the posterior is negative and 0 when it is zero or positive. It is refreshed on load and on each return.
- R7: While `vtc_valid` is high and `vtc_ready` is low, the output message, index and layer hold steady and `vn_ready` is low.
- R8: An `iter_end` pulse with `checks_ok` high ends the decode: `dec_done` and `early_term` go high on the next cycle, and `iter_cnt` counts that iteration.
- R9: Without `checks_ok`, `dec_done` rises with `early_term` low on the `iter_end` pulse that brings `iter_cnt` to the cap. The cap is `max_iter`, or the default of 45 when `max_iter` is 0.
- R10: While `dec_done` is high, all readies are low, so requests and returns are ignored and the decoded bits do not change.
- R11: After reset, all readies, `vtc_valid`, `dec_done` and `early_term` are low and `iter_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new decode (load phase) |
| max_iter | input | ITER_W | Iteration cap; 0 selects the default |
| ld_valid | input | 1 | Channel LLR valid |
| ld_ready | output | 1 | Unit accepts a channel LLR |
| ld_llr | input | LLR_W | Channel LLR, two's complement |
| ld_short | input | 1 | Position is shortened |
| vn_valid | input | 1 | Request valid |
| vn_ready | output | 1 | Unit accepts a request |
| vn_idx | input | IDX_W | Requested variable |
| vn_layer | input | LAY_W | Requested layer, below LAYERS |
| vtc_valid | output | 1 | Outgoing message valid |
| vtc_ready | input | 1 | Check side takes the message |
| vtc_llr | output | LLR_W | Variable-to-check message |
| vtc_idx | output | IDX_W | Variable of the message |
| vtc_layer | output | LAY_W | Layer of the message |
| ret_valid | input | 1 | Returned check message valid |
| ret_ready | output | 1 | Unit accepts a return |
| ret_idx | input | IDX_W | Variable of the return |
| ret_layer | input | LAY_W | Layer of the return |
| ret_msg | input | LLR_W | New check-to-variable message |
| iter_end | input | 1 | End-of-iteration pulse |
| checks_ok | input | 1 | All parity checks satisfied |
| iter_cnt | output | ITER_W | Iterations completed |
| dec_done | output | 1 | Decode finished |
| early_term | output | 1 | Finished by parity success |
| hd_addr | input | IDX_W | Decoded-bit read address |
| hd_bit | output | 1 | Decoded bit at hd_addr |

## Verification
The assertions watch the properties that hold on every cycle. These are the hold and stall rule of the output stream, the exclusion of the load phase from the decode phase, and the silence of all readies after completion. They also check that no outgoing message takes the value -128, and that each completion matches its cause, either a parity pass or the iteration cap. The arithmetic is shown only by the bench scenarios. These cover the subtraction and addition across layers, saturation at both rails, forced values on shortened positions, clearing of old check messages on reload, and the hard-decision signs. The bench checks them against a running model of posteriors and stored messages.

// File: rtl/ldpc_vnu_pkg.sv
package ldpc_vnu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } vnu_state_e;
endpackage

// File: rtl/vnu_sat.sv
// Symmetric saturation of a signed value to +/-(2^(OUT_W-1)-1).
module vnu_sat #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int MAXV = (1 << (OUT_W - 1)) - 1;
  localparam logic signed [IN_W-1:0] HI = IN_W'(MAXV);
  localparam logic signed [IN_W-1:0] LO = -HI;

  always_comb begin
    if (din > HI)      dout = OUT_W'(HI);
    else if (din < LO) dout = OUT_W'(LO);
    else               dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/vnu_msg_store.sv
// Posterior, per-layer check messages, kept outgoing messages, decoded bits.
module vnu_msg_store #(
  parameter int N_VAR  = 64,
  parameter int LAYERS = 3,
  parameter int LLR_W  = 8,
  parameter int IDX_W  = 6,
  parameter int LAY_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_we,
  input  logic [IDX_W-1:0]         ld_addr,
  input  logic signed [LLR_W-1:0]  ld_val,
  input  logic                     iss_we,
  input  logic [IDX_W-1:0]         iss_addr,
  input  logic [LAY_W-1:0]         iss_layer,
  input  logic signed [LLR_W-1:0]  iss_vtc,
  output logic signed [LLR_W-1:0]  post_rd,
  output logic signed [LLR_W-1:0]  rcv_rd,
  input  logic                     ret_we,
  input  logic [IDX_W-1:0]         ret_addr,
  input  logic [LAY_W-1:0]         ret_layer,
  input  logic signed [LLR_W-1:0]  ret_post,
  input  logic signed [LLR_W-1:0]  ret_msg,
  output logic signed [LLR_W-1:0]  vtc_rd,
  input  logic [IDX_W-1:0]         hd_addr,
  output logic                     hd_bit
);
  logic signed [LLR_W-1:0] post_mem [N_VAR];
  logic signed [LLR_W-1:0] vtc_mem  [N_VAR];
  logic signed [LLR_W-1:0] rcv_each [LAYERS];
  logic [N_VAR-1:0]        hd_q;

  always_ff @(posedge clk) begin
    if (ld_we) begin
      post_mem[ld_addr] <= ld_val;
      vtc_mem[ld_addr]  <= ld_val;
    end else begin
      if (iss_we) vtc_mem[iss_addr]  <= iss_vtc;
      if (ret_we) post_mem[ret_addr] <= ret_post;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hd_q <= '0;
    else if (ld_we)  hd_q[ld_addr]  <= ld_val[LLR_W-1];
    else if (ret_we) hd_q[ret_addr] <= ret_post[LLR_W-1];
  end

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    logic signed [LLR_W-1:0] rcv_mem [N_VAR];
    always_ff @(posedge clk) begin
      if (ld_we) rcv_mem[ld_addr] <= '0;
      else if (ret_we && ret_layer == LAY_W'(l)) rcv_mem[ret_addr] <= ret_msg;
    end
    assign rcv_each[l] = rcv_mem[iss_addr];
  end

  always_comb begin
    rcv_rd = '0;
    for (int l = 0; l < LAYERS; l++)
      if (iss_layer == LAY_W'(l)) rcv_rd = rcv_each[l];
  end

  assign post_rd = post_mem[iss_addr];
  assign vtc_rd  = vtc_mem[ret_addr];
  assign hd_bit  = hd_q[hd_addr];
endmodule

// File: rtl/vnu_iter_ctrl.sv
// Phase sequencing, load counting, iteration counting and termination.
module vnu_iter_ctrl
  import ldpc_vnu_pkg::*;
#(
  parameter int N_VAR        = 64,
  parameter int IDX_W        = 6,
  parameter int ITER_W       = 8,
  parameter int DEF_MAX_ITER = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ITER_W-1:0] max_iter,
  input  logic              ld_fire,
  input  logic              iter_end,
  input  logic              checks_ok,
  output vnu_state_e        state,
  output logic [IDX_W-1:0]  ld_cnt,
  output logic [ITER_W-1:0] iter_cnt,
  output logic              early_term
);
  logic [ITER_W-1:0] limit;
  logic [ITER_W:0]   next_cnt;

  assign limit    = (max_iter == '0) ? ITER_W'(DEF_MAX_ITER) : max_iter;
  assign next_cnt = {1'b0, iter_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ld_cnt     <= '0;
      iter_cnt   <= '0;
      early_term <= 1'b0;
    end else if (start) begin
      state      <= ST_LOAD;
      ld_cnt     <= '0;
      iter_cnt   <= '0;
      early_term <= 1'b0;
    end else begin
      case (state)
        ST_LOAD: if (ld_fire) begin
          if (ld_cnt == IDX_W'(N_VAR - 1)) state <= ST_RUN;
          else ld_cnt <= ld_cnt + 1'b1;
        end
        ST_RUN: if (iter_end) begin
          iter_cnt <= next_cnt[ITER_W-1:0];
          if (checks_ok) begin
            state      <= ST_DONE;
            early_term <= 1'b1;
          end else if (next_cnt >= {1'b0, limit}) begin
            state <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_vnu.sv
module ldpc_vnu
  import ldpc_vnu_pkg::*;
#(
  parameter int N_VAR        = 64,
  parameter int LAYERS       = 3,
  parameter int LLR_W        = 8,
  parameter int SUM_W        = 10,
  parameter int ITER_W       = 8,
  parameter int DEF_MAX_ITER = 45,
  localparam int IDX_W       = $clog2(N_VAR),
  localparam int LAY_W       = $clog2(LAYERS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ITER_W-1:0]       max_iter,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic signed [LLR_W-1:0] ld_llr,
  input  logic                    ld_short,
  input  logic                    vn_valid,
  output logic                    vn_ready,
  input  logic [IDX_W-1:0]        vn_idx,
  input  logic [LAY_W-1:0]        vn_layer,
  output logic                    vtc_valid,
  input  logic                    vtc_ready,
  output logic signed [LLR_W-1:0] vtc_llr,
  output logic [IDX_W-1:0]        vtc_idx,
  output logic [LAY_W-1:0]        vtc_layer,
  input  logic                    ret_valid,
  output logic                    ret_ready,
  input  logic [IDX_W-1:0]        ret_idx,
  input  logic [LAY_W-1:0]        ret_layer,
  input  logic signed [LLR_W-1:0] ret_msg,
  input  logic                    iter_end,
  input  logic                    checks_ok,
  output logic [ITER_W-1:0]       iter_cnt,
  output logic                    dec_done,
  output logic                    early_term,
  input  logic [IDX_W-1:0]        hd_addr,
  output logic                    hd_bit
);
  localparam logic signed [LLR_W-1:0] LLR_MAX = {1'b0, {(LLR_W-1){1'b1}}};

  vnu_state_e              state;
  logic [IDX_W-1:0]        ld_cnt;
  logic                    ld_fire, iss_fire, ret_fire;
  logic signed [LLR_W-1:0] ld_sat, ld_val;
  logic signed [LLR_W-1:0] post_rd, rcv_rd, vtc_rd;
  logic signed [SUM_W-1:0] iss_diff, ret_sum;
  logic signed [LLR_W-1:0] iss_vtc, ret_clamp, ret_post;

  // handshakes
  assign ld_ready  = (state == ST_LOAD);
  assign ret_ready = (state == ST_RUN);
  assign vn_ready  = (state == ST_RUN) && (!vtc_valid || vtc_ready);
  assign ld_fire   = ld_valid && ld_ready;
  assign iss_fire  = vn_valid && vn_ready;
  assign ret_fire  = ret_valid && ret_ready;
  assign dec_done  = (state == ST_DONE);

  // load path: clamp, then force shortened positions
  vnu_sat #(.IN_W(LLR_W), .OUT_W(LLR_W)) u_sat_ld (.din(ld_llr), .dout(ld_sat));
  assign ld_val = ld_short ? LLR_MAX : ld_sat;

  // issue path: posterior minus this layer's old check message
  assign iss_diff = SUM_W'(post_rd) - SUM_W'(rcv_rd);
  vnu_sat #(.IN_W(SUM_W), .OUT_W(LLR_W)) u_sat_iss (.din(iss_diff), .dout(iss_vtc));

  // return path: kept outgoing message plus new check message
  vnu_sat #(.IN_W(LLR_W), .OUT_W(LLR_W)) u_sat_ret (.din(ret_msg), .dout(ret_clamp));
  assign ret_sum = SUM_W'(vtc_rd) + SUM_W'(ret_clamp);
  vnu_sat #(.IN_W(SUM_W), .OUT_W(LLR_W)) u_sat_post (.din(ret_sum), .dout(ret_post));

  // output register stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vtc_valid <= 1'b0;
      vtc_llr   <= '0;
      vtc_idx   <= '0;
      vtc_layer <= '0;
    end else if (start) begin
      vtc_valid <= 1'b0;
    end else if (iss_fire) begin
      vtc_valid <= 1'b1;
      vtc_llr   <= iss_vtc;
      vtc_idx   <= vn_idx;
      vtc_layer <= vn_layer;
    end else if (vtc_ready) begin
      vtc_valid <= 1'b0;
    end
  end

  vnu_msg_store #(
    .N_VAR(N_VAR), .LAYERS(LAYERS), .LLR_W(LLR_W), .IDX_W(IDX_W), .LAY_W(LAY_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_we    (ld_fire),
    .ld_addr  (ld_cnt),
    .ld_val   (ld_val),
    .iss_we   (iss_fire),
    .iss_addr (vn_idx),
    .iss_layer(vn_layer),
    .iss_vtc  (iss_vtc),
    .post_rd  (post_rd),
    .rcv_rd   (rcv_rd),
    .ret_we   (ret_fire),
    .ret_addr (ret_idx),
    .ret_layer(ret_layer),
    .ret_post (ret_post),
    .ret_msg  (ret_clamp),
    .vtc_rd   (vtc_rd),
    .hd_addr  (hd_addr),
    .hd_bit   (hd_bit)
  );

  vnu_iter_ctrl #(
    .N_VAR(N_VAR), .IDX_W(IDX_W), .ITER_W(ITER_W), .DEF_MAX_ITER(DEF_MAX_ITER)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .max_iter  (max_iter),
    .ld_fire   (ld_fire),
    .iter_end  (iter_end),
    .checks_ok (checks_ok),
    .state     (state),
    .ld_cnt    (ld_cnt),
    .iter_cnt  (iter_cnt),
    .early_term(early_term)
  );
endmodule

// File: rtl/ldpc_vnu_chk.sv
module ldpc_vnu_chk #(
  parameter int LLR_W        = 8,
  parameter int IDX_W        = 6,
  parameter int LAY_W        = 2,
  parameter int ITER_W       = 8,
  parameter int DEF_MAX_ITER = 45
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ITER_W-1:0]       max_iter,
  input logic                    ld_ready,
  input logic                    vn_ready,
  input logic                    ret_ready,
  input logic                    vtc_valid,
  input logic                    vtc_ready,
  input logic signed [LLR_W-1:0] vtc_llr,
  input logic [IDX_W-1:0]        vtc_idx,
  input logic [LAY_W-1:0]        vtc_layer,
  input logic                    iter_end,
  input logic                    checks_ok,
  input logic [ITER_W-1:0]       iter_cnt,
  input logic                    dec_done,
  input logic                    early_term
);
  logic [ITER_W-1:0] cap;
  assign cap = (max_iter == '0) ? ITER_W'(DEF_MAX_ITER) : max_iter;

  a_r1_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (!vn_ready && !ret_ready));

  a_r2_no_neg_rail: assert property (@(posedge clk) disable iff (!rst_n)
    vtc_valid |-> (vtc_llr != {1'b1, {(LLR_W-1){1'b0}}}));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vtc_valid && !vtc_ready) |=>
      (vtc_valid && $stable(vtc_llr) && $stable(vtc_idx) && $stable(vtc_layer)));

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (vtc_valid && !vtc_ready) |-> !vn_ready);

  a_r8_early_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_done) && early_term) |-> ($past(iter_end) && $past(checks_ok)));

  a_r9_cap_reached: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_done) && !early_term) |-> (iter_cnt == cap));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> (!vn_ready && !ret_ready && !ld_ready));
endmodule

bind ldpc_vnu ldpc_vnu_chk #(
  .LLR_W(LLR_W), .IDX_W(IDX_W), .LAY_W(LAY_W), .ITER_W(ITER_W), .DEF_MAX_ITER(DEF_MAX_ITER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .max_iter(max_iter), .ld_ready(ld_ready),
  .vn_ready(vn_ready), .ret_ready(ret_ready), .vtc_valid(vtc_valid),
  .vtc_ready(vtc_ready), .vtc_llr(vtc_llr), .vtc_idx(vtc_idx),
  .vtc_layer(vtc_layer), .iter_end(iter_end), .checks_ok(checks_ok),
  .iter_cnt(iter_cnt), .dec_done(dec_done), .early_term(early_term)
);

// File: tb/ldpc_vnu_tb.sv
module ldpc_vnu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int NL  = 3;
  localparam int IW  = 3;
  localparam int LW  = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] max_iter = 0;
  logic ld_valid = 0, ld_short = 0, ld_ready;
  logic signed [7:0] ld_llr = 0;
  logic vn_valid = 0, vn_ready;
  logic [IW-1:0] vn_idx = 0;
  logic [LW-1:0] vn_layer = 0;
  logic vtc_valid, vtc_ready = 1;
  logic signed [7:0] vtc_llr;
  logic [IW-1:0] vtc_idx;
  logic [LW-1:0] vtc_layer;
  logic ret_valid = 0, ret_ready;
  logic [IW-1:0] ret_idx = 0;
  logic [LW-1:0] ret_layer = 0;
  logic signed [7:0] ret_msg = 0;
  logic iter_end = 0, checks_ok = 0;
  logic [7:0] iter_cnt;
  logic dec_done, early_term;
  logic [IW-1:0] hd_addr = 0;
  logic hd_bit;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int post_m [N];
  int vtc_m  [N];
  int rcv_m  [NL][N];

  always #(CLK_PERIOD/2) clk = ~clk;

  ldpc_vnu #(.N_VAR(N), .LAYERS(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_iter(max_iter),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_llr(ld_llr), .ld_short(ld_short),
    .vn_valid(vn_valid), .vn_ready(vn_ready), .vn_idx(vn_idx), .vn_layer(vn_layer),
    .vtc_valid(vtc_valid), .vtc_ready(vtc_ready), .vtc_llr(vtc_llr),
    .vtc_idx(vtc_idx), .vtc_layer(vtc_layer),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_idx(ret_idx),
    .ret_layer(ret_layer), .ret_msg(ret_msg),
    .iter_end(iter_end), .checks_ok(checks_ok), .iter_cnt(iter_cnt),
    .dec_done(dec_done), .early_term(early_term), .hd_addr(hd_addr), .hd_bit(hd_bit));

  function automatic int satb(int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  task automatic chk_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_hd(string req);
    for (int i = 0; i < N; i++) begin
      hd_addr = i[IW-1:0];
      #1;
      chk_eq(req, int'(hd_bit), (post_m[i] < 0) ? 1 : 0);
    end
  endtask

  task automatic pulse_start(int cap);
    @(negedge clk); max_iter = cap[7:0]; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic load(int llrs[N], bit sh[N]);
    for (int i = 0; i < N; i++) begin
      ld_valid = 1; ld_llr = llrs[i][7:0]; ld_short = sh[i];
      chk_eq("R1 ld_ready during load", int'(ld_ready), 1);
      chk_eq("R1 no request while loading", int'(vn_ready), 0);
      @(negedge clk);
      post_m[i] = sh[i] ? 127 : satb(llrs[i]);
      vtc_m[i]  = post_m[i];
      for (int l = 0; l < NL; l++) rcv_m[l][i] = 0;
    end
    ld_valid = 0; ld_short = 0;
    chk_eq("R1 ld_ready low after N", int'(ld_ready), 0);
  endtask

  task automatic issue(int idx, int layer, string req);
    int exp;
    @(negedge clk); vn_valid = 1; vn_idx = idx[IW-1:0]; vn_layer = layer[LW-1:0];
    while (!vn_ready) @(negedge clk);
    @(negedge clk); vn_valid = 0;
    exp = satb(post_m[idx] - rcv_m[layer][idx]);
    vtc_m[idx] = exp;
    chk_eq(req, int'(vtc_llr), exp);
    chk_eq({req, " idx"}, int'(vtc_idx), idx);
  endtask

  task automatic give_back(int idx, int layer, int msg);
    @(negedge clk); ret_valid = 1; ret_idx = idx[IW-1:0];
    ret_layer = layer[LW-1:0]; ret_msg = msg[7:0];
    @(negedge clk); ret_valid = 0;
    rcv_m[layer][idx] = satb(msg);
    post_m[idx] = satb(vtc_m[idx] + satb(msg));
  endtask

  task automatic end_iter(bit ok);
    @(negedge clk); iter_end = 1; checks_ok = ok;
    @(negedge clk); iter_end = 0; checks_ok = 0;
  endtask

  // R11
  task automatic t_reset;
    chk_eq("R11 ld_ready", int'(ld_ready), 0);
    chk_eq("R11 vn_ready", int'(vn_ready), 0);
    chk_eq("R11 ret_ready", int'(ret_ready), 0);
    chk_eq("R11 vtc_valid", int'(vtc_valid), 0);
    chk_eq("R11 dec_done", int'(dec_done), 0);
    chk_eq("R11 early_term", int'(early_term), 0);
    chk_eq("R11 iter_cnt", int'(iter_cnt), 0);
  endtask

  // R1, R2, R3, R6 on a first pattern
  task automatic t_load_first;
    int  l0[N] = '{20, -35, 60, -128, 0, 5, -90, 127};
    bit  s0[N] = '{0, 0, 1, 0, 0, 1, 0, 0};
    pulse_start(0);
    load(l0, s0);
    chk_hd("R2/R6 hard bits after load");
    for (int i = 0; i < N; i++) issue(i, 0, "R3 first pass equals posterior");
  endtask

  // R4, R5, R6 across layers, with saturation at both rails
  task automatic t_layers;
    int m0[N] = '{-50, 10, -10, 100, -3, 0, 120, -128};
    int m1[N] = '{100, 100, -127, -100, 60, -127, 120, 127};
    for (int i = 0; i < N; i++) give_back(i, 0, m0[i]);
    chk_hd("R6 hard bits after layer 0");
    for (int i = 0; i < N; i++) issue(i, 1, "R4/R5 layer 1 message");
    for (int i = 0; i < N; i++) give_back(i, 1, m1[i]);
    chk_hd("R6 hard bits after layer 1");
    for (int i = 0; i < N; i++) issue(i, 0, "R4 layer 0 removes old message");
    for (int i = 0; i < N; i++) give_back(i, 0, -m0[i] / 2);
    for (int i = 0; i < N; i++) issue(i, 2, "R5 posterior after second layer 0");
    for (int i = 0; i < N; i++) give_back(i, 2, 7 - 3 * i);
    chk_hd("R6 hard bits after layer 2");
  endtask

  // R7 back-pressure
  task automatic t_backpressure;
    int e0, e1;
    @(negedge clk); vtc_ready = 0; vn_valid = 1; vn_idx = 3; vn_layer = 1;
    @(negedge clk);
    e0 = satb(post_m[3] - rcv_m[1][3]); vtc_m[3] = e0;
    vn_idx = 4; vn_layer = 2;
    for (int k = 0; k < 3; k++) begin
      chk_eq("R7 held valid", int'(vtc_valid), 1);
      chk_eq("R7 held data", int'(vtc_llr), e0);
      chk_eq("R7 held idx", int'(vtc_idx), 3);
      chk_eq("R7 stall ready", int'(vn_ready), 0);
      @(negedge clk);
    end
    vtc_ready = 1;
    @(negedge clk); vn_valid = 0;
    e1 = satb(post_m[4] - rcv_m[2][4]); vtc_m[4] = e1;
    chk_eq("R7 next message after release", int'(vtc_llr), e1);
    chk_eq("R7 next idx after release", int'(vtc_idx), 4);
    give_back(3, 1, rcv_m[1][3]);
    give_back(4, 2, rcv_m[2][4]);
  endtask

  // R8 and R10
  task automatic t_early;
    end_iter(0);
    chk_eq("R8 not done after failing check", int'(dec_done), 0);
    chk_eq("R8 iteration counted", int'(iter_cnt), 1);
    end_iter(1);
    chk_eq("R8 done on parity pass", int'(dec_done), 1);
    chk_eq("R8 early flag", int'(early_term), 1);
    chk_eq("R8 iter_cnt", int'(iter_cnt), 2);
    @(negedge clk); vn_valid = 1; vn_idx = 0; vn_layer = 0;
    ret_valid = 1; ret_idx = 0; ret_layer = 0;
    ret_msg = (post_m[0] < 0) ? 8'sd127 : -8'sd127;
    chk_eq("R10 vn_ready low", int'(vn_ready), 0);
    chk_eq("R10 ret_ready low", int'(ret_ready), 0);
    @(negedge clk); vn_valid = 0; ret_valid = 0;
    chk_eq("R10 no message", int'(vtc_valid), 0);
    chk_hd("R10 bits unchanged");
  endtask

  // R9, fresh load also exercising R2 and R3 again
  task automatic t_cap;
    int  l1[N] = '{-1, 127, -127, 3, -128, 40, -40, 0};
    bit  s1[N] = '{1, 0, 0, 0, 1, 0, 0, 1};
    pulse_start(3);
    load(l1, s1);
    chk_hd("R2/R6 hard bits after reload");
    issue(6, 0, "R3 reload clears old messages");
    give_back(6, 0, 5);
    end_iter(0); end_iter(0);
    chk_eq("R9 not done before cap", int'(dec_done), 0);
    end_iter(0);
    chk_eq("R9 done at cap", int'(dec_done), 1);
    chk_eq("R9 not early", int'(early_term), 0);
    chk_eq("R9 iter_cnt at cap", int'(iter_cnt), 3);
    pulse_start(0);
    load(l1, s1);
    for (int k = 0; k < 44; k++) end_iter(0);
    chk_eq("R9 default cap not yet", int'(dec_done), 0);
    end_iter(0);
    chk_eq("R9 default cap 45", int'(dec_done), 1);
    chk_eq("R9 default iter_cnt", int'(iter_cnt), 45);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_first();
    t_layers();
    t_backpressure();
    t_early();
    t_cap();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule